// File: doc/BRIEF.md
# Multichannel AC Power Accumulator

This block takes interleaved signed voltage and current sample pairs from up to eight measurement channels. For each channel it keeps four filtered results: mean-square voltage, mean-square current, true (active) power and signed reactive power. One arithmetic datapath serves every channel. Each valid sample pair is assigned to the next channel in a fixed rotation. A slow host takes square roots and ratios from these results.

True power is the low-pass average of the instantaneous product of voltage and current. Reactive power is the low-pass average of current times a voltage taken a quarter line-cycle earlier. That earlier voltage comes from a per-channel circular history buffer, whose length the host sets for each of two line-frequency bands. A band input picks which length is in use.

The host reads results through a snapshot. A snapshot request copies all four values of one channel into a holding set at once, so the four values always belong to the same moment. A select input then presents each held value in turn.

Top module: `ac_power_acc`

## Requirements
- R1: After synchronous reset every accumulator and the holding set are zero, and the channel rotation restarts at channel 0; a snapshot of any channel then reads 0 for all four results.
- R2: The n-th sample pair accepted with `smp_valid` high after reset is applied to channel n mod NCH; cycles with `smp_valid` low do not advance the rotation.
- R3: On each accepted sample, the channel's mean-square voltage y becomes y + ((v*v - y) >>> K), with y a 48-bit signed value and K taken from `cfg_shift`.
- R4: The mean-square current is updated the same way with i*i.
- R5: True power is updated the same way with the signed product v*i, and a negative product drives it negative.
- R6: Reactive power is updated the same way with i*vd. Here vd is the voltage of the same channel accepted L samples earlier, with L = `cfg_len_lo` when `cfg_band` is 0 and `cfg_len_hi` when it is 1. vd is 0 while fewer than L samples of that channel have been accepted since reset, and vd equals the current voltage when L is 0.
- R7: A high `snap_req` copies the four results of channel `snap_ch` into the holding set at the next clock edge. `rd_data` shows held value `rd_sel` (0 mean-square voltage, 1 mean-square current, 2 true power, 3 reactive power) and does not change, whatever samples arrive, until the next snapshot.
- R8: Reset also clears the history pointers and fill counts, so the reactive term uses vd = 0 again after a reset mid-run.
- R9: Both mean-square results are never negative.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| smp_valid | input | 1 | A sample pair is presented this cycle |
| smp_v | input | 16 | Signed voltage sample |
| smp_i | input | 16 | Signed current sample |
| cfg_band | input | 1 | 0 selects the low-band quarter-cycle length, 1 the high-band length |
| cfg_len_lo | input | 8 | Quarter-cycle delay in samples for the low band |
| cfg_len_hi | input | 8 | Quarter-cycle delay in samples for the high band |
| cfg_shift | input | 6 | Filter shift K |
| snap_req | input | 1 | Copy the results of one channel into the holding set |
| snap_ch | input | 3 | Channel copied by a snapshot |
| rd_sel | input | 2 | Which held result appears on rd_data |
| rd_data | output | 48 | Selected held result, signed |

## Verification
The assertions assume that `smp_valid` is low while reset is asserted. They also assume that the configuration inputs change only when no sample is in flight. Under that assumption, a delay length and a filter shift always apply to a whole sample. The stimulus changes the band, the lengths and the shift only after an idle gap of several cycles. It keeps the shift between 0 and 10, which keeps the filters meaningful. It also holds `smp_valid` low during every reset.

// File: rtl/acp_pkg.sv
package acp_pkg;
    localparam int QTY = 4;
    typedef enum logic [1:0] {
        Q_VSQ = 2'd0,
        Q_ISQ = 2'd1,
        Q_ACT = 2'd2,
        Q_REA = 2'd3
    } qty_e;
endpackage

// File: rtl/acp_delay.sv
module acp_delay #(
    parameter int NCH   = 8,
    parameter int SW    = 16,
    parameter int DEPTH = 256
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         wr_en,
    input  logic [$clog2(NCH)-1:0]       wr_ch,
    input  logic signed [SW-1:0]         wr_v,
    input  logic [$clog2(DEPTH)-1:0]     len,
    output logic signed [SW-1:0]         vd
);
    localparam int AW = $clog2(DEPTH);

    typedef struct packed {
        logic [NCH-1:0][AW-1:0] wp;
        logic [NCH-1:0][AW-1:0] fill;
        logic [SW-1:0]          vd;
    } dly_t;

    dly_t d, q;
    logic [AW-1:0] rd_addr;
    logic [SW-1:0] mem [NCH][DEPTH];

    always_comb begin
        d       = q;
        rd_addr = q.wp[wr_ch] - len;
        if (wr_en) begin
            if (len == '0)
                d.vd = wr_v;
            else if (q.fill[wr_ch] < len)
                d.vd = '0;
            else
                d.vd = mem[wr_ch][rd_addr];
            d.wp[wr_ch] = q.wp[wr_ch] + 1'b1;
            if (q.fill[wr_ch] != '1)
                d.fill[wr_ch] = q.fill[wr_ch] + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) q <= '0;
        else     q <= d;
    end

    always_ff @(posedge clk) begin
        if (wr_en) mem[wr_ch][q.wp[wr_ch]] <= wr_v;
    end

    assign vd = $signed(q.vd);

    // R2/R6: the write pointer of the written channel moves by exactly one
    p_ptr_step_r6: assert property (@(posedge clk) disable iff (rst)
        $past(wr_en) && !$past(rst) |->
            q.wp[$past(wr_ch)] == AW'($past(q.wp[wr_ch]) + 1'b1));

    // R6: a too-short history gives a zero delayed voltage
    p_empty_zero_r6: assert property (@(posedge clk) disable iff (rst)
        wr_en && len != '0 && q.fill[wr_ch] < len |=> q.vd == '0);
endmodule

// File: rtl/acp_mac.sv
module acp_mac
    import acp_pkg::*;
#(
    parameter int NCH  = 8,
    parameter int SW   = 16,
    parameter int ACCW = 48,
    parameter int KW   = 6
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      en,
    input  logic [$clog2(NCH)-1:0]    ch,
    input  logic signed [SW-1:0]      v,
    input  logic signed [SW-1:0]      i,
    input  logic signed [SW-1:0]      vd,
    input  logic [KW-1:0]             k,
    input  logic [$clog2(NCH)-1:0]    rd_ch,
    output logic [QTY*ACCW-1:0]       rd_acc
);
    localparam int PW = 2 * SW;

    typedef struct packed {
        logic [NCH-1:0][QTY-1:0][ACCW-1:0] acc;
    } mac_t;

    mac_t d, q;
    logic signed [PW-1:0] p_vv, p_ii, p_vi, p_dq;

    function automatic logic [ACCW-1:0] lpf_step(
        input logic [ACCW-1:0]     y,
        input logic signed [PW-1:0] x,
        input logic [KW-1:0]       sh
    );
        logic signed [ACCW-1:0] ys, xs, df;
        ys = $signed(y);
        xs = $signed({{(ACCW-PW){x[PW-1]}}, x});
        df = xs - ys;
        return ys + (df >>> sh);
    endfunction

    always_comb begin
        p_vv = v * v;
        p_ii = i * i;
        p_vi = v * i;
        p_dq = vd * i;
        d    = q;
        if (en) begin
            d.acc[ch][Q_VSQ] = lpf_step(q.acc[ch][Q_VSQ], p_vv, k);
            d.acc[ch][Q_ISQ] = lpf_step(q.acc[ch][Q_ISQ], p_ii, k);
            d.acc[ch][Q_ACT] = lpf_step(q.acc[ch][Q_ACT], p_vi, k);
            d.acc[ch][Q_REA] = lpf_step(q.acc[ch][Q_REA], p_dq, k);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) q <= '0;
        else     q <= d;
    end

    assign rd_acc = q.acc[rd_ch];

    // R9: mean-square results stay non-negative
    p_msq_nonneg_r9: assert property (@(posedge clk) disable iff (rst)
        !q.acc[rd_ch][Q_VSQ][ACCW-1] && !q.acc[rd_ch][Q_ISQ][ACCW-1]);

    // R3: accumulators hold when no sample is processed
    p_idle_hold_r3: assert property (@(posedge clk) disable iff (rst)
        !$past(en) && !$past(rst) |-> $stable(q.acc));
endmodule

// File: rtl/ac_power_acc.sv
module ac_power_acc
    import acp_pkg::*;
#(
    parameter int NCH   = 8,
    parameter int SW    = 16,
    parameter int DEPTH = 256,
    parameter int ACCW  = 48,
    parameter int KW    = 6
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       smp_valid,
    input  logic [SW-1:0]              smp_v,
    input  logic [SW-1:0]              smp_i,
    input  logic                       cfg_band,
    input  logic [$clog2(DEPTH)-1:0]   cfg_len_lo,
    input  logic [$clog2(DEPTH)-1:0]   cfg_len_hi,
    input  logic [KW-1:0]              cfg_shift,
    input  logic                       snap_req,
    input  logic [$clog2(NCH)-1:0]     snap_ch,
    input  logic [1:0]                 rd_sel,
    output logic [ACCW-1:0]            rd_data
);
    localparam int CHW = $clog2(NCH);
    localparam int AW  = $clog2(DEPTH);

    typedef struct packed {
        logic [CHW-1:0]             ch;
        logic                       a_vld;
        logic [CHW-1:0]             a_ch;
        logic [SW-1:0]              a_v;
        logic [SW-1:0]              a_i;
        logic [QTY-1:0][ACCW-1:0]   shadow;
    } top_t;

    top_t d, q;
    logic [AW-1:0]         len_sel;
    logic signed [SW-1:0]  vd;
    logic [QTY*ACCW-1:0]   mac_rd;

    assign len_sel = cfg_band ? cfg_len_hi : cfg_len_lo;

    acp_delay #(.NCH(NCH), .SW(SW), .DEPTH(DEPTH)) u_dly (
        .clk   (clk),
        .rst   (rst),
        .wr_en (smp_valid),
        .wr_ch (q.ch),
        .wr_v  ($signed(smp_v)),
        .len   (len_sel),
        .vd    (vd)
    );

    acp_mac #(.NCH(NCH), .SW(SW), .ACCW(ACCW), .KW(KW)) u_mac (
        .clk    (clk),
        .rst    (rst),
        .en     (q.a_vld),
        .ch     (q.a_ch),
        .v      ($signed(q.a_v)),
        .i      ($signed(q.a_i)),
        .vd     (vd),
        .k      (cfg_shift),
        .rd_ch  (snap_ch),
        .rd_acc (mac_rd)
    );

    always_comb begin
        d       = q;
        d.a_vld = smp_valid;
        if (smp_valid) begin
            d.a_ch = q.ch;
            d.a_v  = smp_v;
            d.a_i  = smp_i;
            d.ch   = (q.ch == CHW'(NCH - 1)) ? '0 : q.ch + 1'b1;
        end
        if (snap_req)
            d.shadow = mac_rd;
    end

    always_ff @(posedge clk) begin
        if (rst) q <= '0;
        else     q <= d;
    end

    assign rd_data = q.shadow[rd_sel];

    // R2: rotation advances by one channel per accepted sample
    p_rr_step_r2: assert property (@(posedge clk) disable iff (rst)
        $past(smp_valid) && !$past(rst) |->
            q.ch == (($past(q.ch) == CHW'(NCH - 1)) ? '0 : CHW'($past(q.ch) + 1'b1)));

    // R2: rotation holds when no sample arrives
    p_rr_hold_r2: assert property (@(posedge clk) disable iff (rst)
        !$past(smp_valid) && !$past(rst) |-> $stable(q.ch));

    // R7: the holding set changes only after a snapshot request
    p_shadow_hold_r7: assert property (@(posedge clk) disable iff (rst)
        !$past(snap_req) && !$past(rst) |-> $stable(q.shadow));
endmodule

// File: tb/sim_ac_power_acc.sv
`timescale 1ns/1ps
module sim_ac_power_acc;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        smp_valid = 1'b0;
    logic [15:0] smp_v = '0, smp_i = '0;
    logic        cfg_band = 1'b0;
    logic [7:0]  cfg_len_lo = '0, cfg_len_hi = '0;
    logic [5:0]  cfg_shift = '0;
    logic        snap_req = 1'b0;
    logic [2:0]  snap_ch = '0;
    logic [1:0]  rd_sel = '0;
    logic [47:0] rd_data;

    int n_chk = 0, n_bad = 0;
    longint macc [8][4];
    int hist [8][256];
    int hwp [8];
    int hcnt [8];
    int mch;
    longint saved [4];

    always #2 clk = ~clk;

    ac_power_acc u0 (
        .clk(clk), .rst(rst), .smp_valid(smp_valid), .smp_v(smp_v), .smp_i(smp_i),
        .cfg_band(cfg_band), .cfg_len_lo(cfg_len_lo), .cfg_len_hi(cfg_len_hi),
        .cfg_shift(cfg_shift), .snap_req(snap_req), .snap_ch(snap_ch),
        .rd_sel(rd_sel), .rd_data(rd_data)
    );

    function automatic longint filt(longint y, longint x, int k);
        return y + ((x - y) >>> k);
    endfunction

    task automatic chk(string tag, longint got, longint exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s got=%0d exp=%0d", tag, got, exp);
        end
    endtask

    task automatic model_clear();
        for (int c = 0; c < 8; c++) begin
            for (int q = 0; q < 4; q++) macc[c][q] = 0;
            hwp[c] = 0;
            hcnt[c] = 0;
        end
        mch = 0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        smp_valid = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        model_clear();
    endtask

    // drives one sample for one cycle; model updated with the config in force
    task automatic send(int v, int i);
        int len, vd;
        @(negedge clk);
        smp_valid = 1'b1;
        smp_v = 16'(v);
        smp_i = 16'(i);
        len = cfg_band ? int'(cfg_len_hi) : int'(cfg_len_lo);
        if (len == 0) vd = v;
        else if (hcnt[mch] < len) vd = 0;
        else vd = hist[mch][(hwp[mch] - len) & 255];
        hist[mch][hwp[mch]] = v;
        hwp[mch] = (hwp[mch] + 1) & 255;
        if (hcnt[mch] < 255) hcnt[mch]++;
        macc[mch][0] = filt(macc[mch][0], longint'(v) * v, cfg_shift);
        macc[mch][1] = filt(macc[mch][1], longint'(i) * i, cfg_shift);
        macc[mch][2] = filt(macc[mch][2], longint'(v) * i, cfg_shift);
        macc[mch][3] = filt(macc[mch][3], longint'(vd) * i, cfg_shift);
        mch = (mch + 1) % 8;
    endtask

    task automatic idle(int n);
        @(negedge clk);
        smp_valid = 1'b0;
        repeat (n) @(negedge clk);
    endtask

    task automatic snap(int c);
        @(negedge clk);
        snap_req = 1'b1;
        snap_ch = 3'(c);
        @(negedge clk);
        snap_req = 1'b0;
    endtask

    task automatic read_q(int q, output longint val);
        rd_sel = 2'(q);
        #1;
        val = longint'($signed(rd_data));
    endtask

    task automatic cmp_ch(int c, string ctx);
        longint val;
        snap(c);
        read_q(0, val); chk($sformatf("R3 %s ch%0d msq-v", ctx, c), val, macc[c][0]);
        read_q(1, val); chk($sformatf("R4 %s ch%0d msq-i", ctx, c), val, macc[c][1]);
        read_q(2, val); chk($sformatf("R5 %s ch%0d active", ctx, c), val, macc[c][2]);
        read_q(3, val); chk($sformatf("R6 %s ch%0d reactive", ctx, c), val, macc[c][3]);
    endtask

    initial begin
        #600000;
        n_chk++;
        n_bad++;
        $display("FAIL watchdog expired got=running exp=done");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        longint val;
        void'($urandom(32'd1234));
        model_clear();
        do_reset();

        // R1: zero after reset
        for (int c = 0; c < 8; c += 7) begin
            snap(c);
            for (int q = 0; q < 4; q++) begin
                read_q(q, val);
                chk($sformatf("R1 reset ch%0d q%0d", c, q), val, 0);
            end
        end

        // R2: rotation order, K=0 gives y=x
        cfg_shift = 6'd0; cfg_band = 1'b0; cfg_len_lo = 8'd0;
        send(100, 2); send(200, 3); send(300, 4);
        idle(3);
        snap(1);
        read_q(0, val); chk("R2 second sample lands on ch1", val, 40000);
        snap(3);
        read_q(0, val); chk("R2 ch3 untouched", val, 0);
        read_q(3, val); chk("R2 ch3 reactive untouched", val, 0);

        // R5 extremes and sign; L=0 uses undelayed voltage (R6)
        send(-32768, -32768); send(32767, -32768);
        idle(3);
        cmp_ch(3, "extreme");
        cmp_ch(4, "negative");
        snap(4);
        read_q(2, val); chk("R5 negative active power", val < 0, 1);

        // R6 band selection
        cfg_len_lo = 8'd2; cfg_len_hi = 8'd5; cfg_shift = 6'd1;
        for (int b = 0; b < 2; b++) begin
            cfg_band = b[0];
            for (int n = 0; n < 48; n++)
                send(($urandom % 60000) - 30000, ($urandom % 60000) - 30000);
            idle(3);
            for (int c = 0; c < 8; c++) cmp_ch(c, b ? "band-hi" : "band-lo");
        end

        // random bursts with random configuration
        for (int r = 0; r < 20; r++) begin
            cfg_shift = 6'($urandom % 11);
            cfg_band = 1'($urandom);
            cfg_len_lo = 8'($urandom);
            cfg_len_hi = 8'($urandom % 40);
            for (int n = 0; n < 8 + ($urandom % 300); n++)
                send(int'($signed(16'($urandom))), int'($signed(16'($urandom))));
            idle(3);
            cmp_ch($urandom % 8, "random");
            cmp_ch($urandom % 8, "random");
        end

        // R7: held values unaffected by later samples
        snap(2);
        for (int q = 0; q < 4; q++) read_q(q, saved[q]);
        for (int n = 0; n < 40; n++) send(12345, -4321);
        idle(3);
        for (int q = 0; q < 4; q++) begin
            read_q(q, val);
            chk($sformatf("R7 hold q%0d", q), val, saved[q]);
        end
        cmp_ch(2, "after-hold");

        // R8: reset mid-run clears history
        do_reset();
        cfg_band = 1'b0; cfg_len_lo = 8'd3; cfg_shift = 6'd0;
        for (int n = 0; n < 8; n++) send(20000, 15000);
        idle(3);
        for (int c = 0; c < 8; c += 3) begin
            snap(c);
            read_q(3, val); chk($sformatf("R8 reactive zero ch%0d", c), val, 0);
            read_q(0, val); chk($sformatf("R8 msq after reset ch%0d", c), val, 400000000);
        end

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule